// File: doc/BRIEF.md
# Supply Supervisor with Write Protect

This block is the digital controller beside a battery-backed static memory. Two analog comparators report on the main supply. One says the supply is inside its operating tolerance, meaning above the write-protect trip point. The other says the supply is still above the lower level at which the memory must move onto its backup cell. From these two flags the supervisor decides when the host processor is held in reset, when memory writes and memory-side inputs are blocked, when the data outputs must float, and when the backup cell feeds the array.

Both flags pass through a two-flop synchronizer. A flag only counts once it has held a new value for a set number of cycles. A four-state machine (normal, protected, battery-backed, reset-hold) drives every output. A down-scalable timer keeps reset asserted for a fixed hold after the supply comes back into tolerance. The backup cell ships disconnected. It is armed permanently once the supply first reaches tolerance after reset, and it can be selected only once it has been armed.

Top module: `supply_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are: `state_o`=2'b10, `rst_req_n_o`=0, `wr_block_o`=1, `out_hiz_o`=1, `bat_sel_o`=0, `bat_armed_o`=0.
- R2: `state_o` reports the power state with the codes 2'b00 normal, 2'b01 protected, 2'b10 battery-backed and 2'b11 reset-hold.
- R3: When the in-tolerance flag is lost while the switchover flag stays high, the block enters protected. There `rst_req_n_o` is 0 (driven), and `wr_block_o` and `out_hiz_o` are both 1.
- R4: When the switchover flag is low, the block enters battery-backed. `bat_sel_o` is 1 there only if `bat_armed_o` is 1, and it is 0 in every other state.
- R5: `bat_armed_o` goes to 1 the first time the filtered in-tolerance flag is seen high after reset. It then stays at 1 whatever the supply does, until `rst_n` is asserted.
- R6: When both flags are high, the block moves from protected or battery-backed into reset-hold. It stays there for exactly `HOLD_CYC` cycles before it enters normal, and it never enters normal from any other state.
- R7: If the in-tolerance flag is lost during reset-hold, the block leaves reset-hold. The next reset-hold then lasts the full `HOLD_CYC` cycles again.
- R8: A flag acts only after its synchronized value has differed from the accepted value for `STABLE_CYC` consecutive cycles. A change lasting fewer cycles has no effect on any output.
- R9: If the in-tolerance flag is lost on the same edge at which the hold would complete, the loss wins: the block goes to protected and shows no normal cycle.
- R10: In normal, `rst_req_n_o` is 1 (released), and `wr_block_o`, `out_hiz_o` and `bat_sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Comparator: supply above write-protect trip point (asynchronous) |
| supply_live_i | input | 1 | Comparator: supply above battery switchover level (asynchronous) |
| rst_req_n_o | output | 1 | Reset request, 0 = drive low, 1 = release |
| wr_block_o | output | 1 | Blocks writes and gates all memory-side inputs |
| out_hiz_o | output | 1 | Requests high-impedance data outputs |
| bat_sel_o | output | 1 | Selects the backup cell as memory supply |
| bat_armed_o | output | 1 | One-time battery enable latch |
| state_o | output | 2 | Power state code |

## Verification
Two events can fall on the same clock edge: the reset-hold timer reaching its final count, and the filtered in-tolerance flag falling. The bench waits until it first samples reset-hold. From there it counts exactly to the edge on which the hold would end, and it times the in-tolerance drop so that the filter accepts the drop on that same edge. It then checks that the state code reads reset-hold one cycle before that edge and protected right after it, with no normal cycle in between. A separate measurement confirms the hold length both on an undisturbed power-up and after a dropout has restarted the hold.

// File: rtl/sg_pkg.sv
// Shared types for the supply supervisor.
package sg_pkg;
    // Power state; the code is reported directly on state_o.
    typedef enum logic [1:0] {
        ST_NORMAL = 2'b00,
        ST_PROT   = 2'b01,
        ST_BATT   = 2'b10,
        ST_HOLD   = 2'b11
    } pwr_state_e;
endpackage

// File: rtl/sg_flag_filter.sv
// sg_flag_filter: brings one asynchronous comparator flag into the clock
// domain through two flops. It then accepts a new level only after the
// synchronized value has disagreed with the accepted one for STABLE_CYC
// consecutive cycles.
// Assumes: STABLE_CYC >= 1; the accepted level resets to 0 (supply absent).
module sg_flag_filter #(
    parameter int STABLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flag_o
);
    localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic          meta_q;
    logic          sync_q;
    logic          filt_q;
    logic [CW-1:0] run_q;

    // Two-flop synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    // Persistence counter: accept a new level once it has held long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
        end else if (sync_q == filt_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            filt_q <= sync_q;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign flag_o = filt_q;

    AST_FILT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q == filt_q) |=> $stable(filt_q)); // R8
endmodule

// File: rtl/sg_hold_timer.sv
// sg_hold_timer: counts cycles while run_i is high and raises done_o
// during the last of HOLD_CYC cycles. Dropping run_i clears the count.
// Assumes: HOLD_CYC >= 2.
module sg_hold_timer #(
    parameter int HOLD_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q == LAST);

    // Advance while running, saturate on the last count, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i)
            cnt_q <= '0;
        else if (!done_o)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R6
    AST_TIMER_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !done_o); // R7
endmodule

// File: rtl/sg_power_fsm.sv
// sg_power_fsm: power-state machine and one-time battery arming latch.
// A loss of the supply always takes priority over completion of the hold.
// Assumes: filtered flags from sg_flag_filter; hold_done_i from
// sg_hold_timer running only in ST_HOLD.
module sg_power_fsm
    import sg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tol_i,
    input  logic       live_i,
    input  logic       hold_done_i,
    output pwr_state_e state_o,
    output logic       armed_o
);
    pwr_state_e state_q, state_d;
    logic       armed_q;

    // Next-state decision; a dropout is checked before hold completion.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: if (!tol_i) state_d = live_i ? ST_PROT : ST_BATT;
            ST_PROT: begin
                if (!live_i)    state_d = ST_BATT;
                else if (tol_i) state_d = ST_HOLD;
            end
            ST_BATT:   if (live_i) state_d = tol_i ? ST_HOLD : ST_PROT;
            ST_HOLD: begin
                if (!tol_i)           state_d = live_i ? ST_PROT : ST_BATT;
                else if (hold_done_i) state_d = ST_NORMAL;
            end
            default:   state_d = ST_BATT;
        endcase
    end

    // State register; reset assumes the supply is not yet present.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BATT;
        else        state_q <= state_d;
    end

    // Freshness latch: arms the backup cell at the first in-tolerance supply.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed_q <= 1'b0;
        else if (tol_i) armed_q <= 1'b1;
    end

    assign state_o = state_q;
    assign armed_o = armed_q;

    AST_DROP_LEAVES_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && !tol_i) |=> state_q != ST_NORMAL); // R3
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q); // R5
    AST_NORMAL_ONLY_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NORMAL && state_q != ST_HOLD) |=> state_q != ST_NORMAL); // R6
    AST_DROP_BEATS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !tol_i) |=> state_q != ST_NORMAL); // R9
endmodule

// File: rtl/supply_guard.sv
// supply_guard: top of the supply supervisor. It filters both comparator
// flags, runs the power FSM and the reset-hold timer, and decodes the
// memory-side controls from the state.
// Assumes: comparator flags are asynchronous; HOLD_CYC is given in clock
// cycles (default: 200 ms at 125 MHz).
module supply_guard
    import sg_pkg::*;
#(
    parameter int STABLE_CYC = 4,
    parameter int HOLD_CYC   = 25_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_i,
    input  logic       supply_live_i,
    output logic       rst_req_n_o,
    output logic       wr_block_o,
    output logic       out_hiz_o,
    output logic       bat_sel_o,
    output logic       bat_armed_o,
    output logic [1:0] state_o
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] filt_flags;
    pwr_state_e       state;
    logic             hold_done;
    logic             armed;

    assign raw_flags = {supply_live_i, supply_ok_i};

    // One synchronizer/filter per comparator flag.
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        sg_flag_filter #(.STABLE_CYC(STABLE_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_flags[g]),
            .flag_o (filt_flags[g])
        );
    end

    sg_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state == ST_HOLD),
        .done_o (hold_done)
    );

    sg_power_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tol_i       (filt_flags[0]),
        .live_i      (filt_flags[1]),
        .hold_done_i (hold_done),
        .state_o     (state),
        .armed_o     (armed)
    );

    // Output decode: anything but normal blocks the memory and holds reset.
    always_comb begin
        rst_req_n_o = (state == ST_NORMAL);
        wr_block_o  = (state != ST_NORMAL);
        out_hiz_o   = (state != ST_NORMAL);
        bat_sel_o   = (state == ST_BATT) && armed;
    end

    assign bat_armed_o = armed;
    assign state_o     = state;

    AST_BATT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel_o |-> (bat_armed_o && state_o == 2'b10)); // R4
    AST_BLOCK_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n_o |-> (wr_block_o && out_hiz_o)); // R3
endmodule

// File: tb/supply_guard_bench.sv
// Bench for supply_guard: a vector table walk, then directed tests.
module supply_guard_bench;
    localparam int S    = 3;
    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ok = 1'b0;
    logic       live = 1'b0;
    logic       rst_req_n, wr_block, out_hiz, bat_sel, bat_armed;
    logic [1:0] st;

    int n_chk = 0;
    int n_bad = 0;

    supply_guard #(.STABLE_CYC(S), .HOLD_CYC(HOLD)) u_supply_guard (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(ok), .supply_live_i(live),
        .rst_req_n_o(rst_req_n), .wr_block_o(wr_block), .out_hiz_o(out_hiz),
        .bat_sel_o(bat_sel), .bat_armed_o(bat_armed), .state_o(st)
    );

    always #4ns clk = ~clk;

    // Vector fields: ok, live, wait[5:0], state[1:0], bat_sel, armed.
    localparam int NV = 9;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b0, 6'd10, 2'b10, 1'b0, 1'b0},
        {1'b0, 1'b1, 6'd10, 2'b01, 1'b0, 1'b0},
        {1'b1, 1'b1, 6'd40, 2'b00, 1'b0, 1'b1},
        {1'b0, 1'b1, 6'd10, 2'b01, 1'b0, 1'b1},
        {1'b0, 1'b0, 6'd10, 2'b10, 1'b1, 1'b1},
        {1'b1, 1'b1, 6'd40, 2'b00, 1'b0, 1'b1},
        {1'b0, 1'b0, 6'd10, 2'b10, 1'b1, 1'b1},
        {1'b0, 1'b1, 6'd10, 2'b01, 1'b0, 1'b1},
        {1'b1, 1'b1, 6'd40, 2'b00, 1'b0, 1'b1}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Checks every output against a state code plus the battery bits.
    task automatic chk_all(input string tag, input logic [1:0] es,
                           input logic eb, input logic ea);
        chk({tag, " state"}, int'(st), int'(es));
        chk({tag, " rst_req_n"}, int'(rst_req_n), int'(es == 2'b00));
        chk({tag, " wr_block"}, int'(wr_block), int'(es != 2'b00));
        chk({tag, " out_hiz"}, int'(out_hiz), int'(es != 2'b00));
        chk({tag, " bat_sel"}, int'(bat_sel), int'(eb));
        chk({tag, " armed"}, int'(bat_armed), int'(ea));
    endtask

    task automatic wait_hold();
        for (int i = 0; i < 100; i++) begin
            if (st == 2'b11) break;
            step(1);
        end
    endtask

    task automatic measure_hold(output int len);
        len = 0;
        while (st == 2'b11 && len < 1000) begin
            len++;
            step(1);
        end
    endtask

    initial begin
        #(8ns * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len;
        // R1 reset state, also R2 battery code
        step(3);
        chk_all("R1 reset", 2'b10, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1);

        // Table walk: R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            ok   = VEC[v][11];
            live = VEC[v][10];
            step(int'(VEC[v][9:4]));
            chk_all($sformatf("R2/R3/R4/R5/R10 vec%0d", v),
                    VEC[v][3:2], VEC[v][1], VEC[v][0]);
        end

        // R8: a drop shorter than STABLE_CYC is ignored
        ok = 1'b0;
        step(S - 1);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step(1);
            chk("R8 glitch state", int'(st), 0);
            chk("R8 glitch rst_req_n", int'(rst_req_n), 1);
        end

        // R6: exact hold length from protected
        ok = 1'b0;
        step(10);
        chk("R3 protected", int'(st), 1);
        ok = 1'b1;
        wait_hold();
        measure_hold(len);
        chk("R6 hold length", len, HOLD);
        chk("R6 normal after hold", int'(st), 0);
        chk("R10 released", int'(rst_req_n), 1);

        // R7: dropout during hold restarts it
        ok = 1'b0;
        step(10);
        ok = 1'b1;
        wait_hold();
        step(10);
        ok = 1'b0;
        step(S);
        ok = 1'b1;
        step(3);
        chk("R7 left hold", int'(st), 1);
        wait_hold();
        measure_hold(len);
        chk("R7 full hold again", len, HOLD);
        chk("R7 normal", int'(st), 0);

        // R9: dropout accepted on the edge the hold would complete
        ok = 1'b0;
        step(10);
        ok = 1'b1;
        wait_hold();
        step(HOLD - 6);
        ok = 1'b0;
        step(5);
        chk("R9 still hold", int'(st), 3);
        step(1);
        chk("R9 dropout wins", int'(st), 1);
        chk("R9 reset driven", int'(rst_req_n), 0);

        // R5: reset clears the arming latch; no arming without tolerance
        live = 1'b0;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(10);
        chk_all("R5 rearm cleared", 2'b10, 1'b0, 1'b0);
        live = 1'b1;
        step(10);
        chk_all("R4/R5 live only", 2'b01, 1'b0, 1'b0);
        live = 1'b0;
        step(10);
        chk("R4 unarmed no select", int'(bat_sel), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule